// File: doc/BRIEF.md
# 64-bit Free-Running Timer with Periodic Compare

This block keeps a 64-bit up-counter that advances by one on every clock while its run bit is set. It also holds a 64-bit compare target. Software reaches both through a 32-bit word-wide register port with a select strobe and a write-enable. Either half of the counter can be preloaded. The compare target is written in two halves, and an optional step value can be added to it on every match. With the step enabled, the block raises events at a fixed period against a count that is never reset.

A match sets a sticky status flag. An enable bit gates that flag onto the `irq` line. A small state machine guards the comparator. It has three states: `CMP_OFF` (comparator disabled), `CMP_ARMED` (watching for equality) and `CMP_SPENT` (a one-shot match has fired). Its transitions are:
- *arm*: OFF to ARMED when the enable bit is set.
- *disarm*: ARMED or SPENT to OFF when the enable bit is cleared.
- *fire*: ARMED to SPENT on a match with the step disabled.
- *rearm*: SPENT to ARMED when either compare half is written.
- *repeat*: ARMED stays in ARMED on a match with the step enabled.

Software reads the count high word, then the low word, then the high word again, and retries if the two high reads differ. For that to work, the carry must move from the low half into the high half within the same clock.

Top module: `frc_cmp_timer`

## Requirements
- R1: After reset the count, compare target, step, control, status and interrupt enable are all zero, and `irq` is low.
- R2: While control bit 8 (register 0x240) is 1, the count rises by exactly one per clock. While it is 0, the count holds.
- R3: The count is read and written as a low word at 0x100 and a high word at 0x104. Writing one half loads that half and holds the other half for that cycle. The carry from low to high takes effect in the same clock.
- R4: The compare target is read and written as a low word at 0x200 and a high word at 0x204. The 32-bit step is at 0x208.
- R5: When control bit 0 is 1, the state is ARMED and the count equals the compare target, the status flag (bit 0 of 0x244) is set at the next clock edge.
- R6: With control bit 1 at 0, a match moves the state machine to SPENT, and no further match fires. A write to either compare half returns it to ARMED.
- R7: With control bit 1 at 1, every match adds the step to the compare target, so matches recur every step clocks.
- R8: If software writes a compare half in the same cycle as an auto-add, the written value wins and the add is dropped.
- R9: Writing 1 to bit 0 of 0x244 clears the status flag, and writing 0 there has no effect. If a match and a clear fall in the same cycle, the flag stays set.
- R10: `irq` is high exactly when the status flag and bit 0 of 0x248 are both 1.
- R11: With control bit 0 at 0, no match sets the status flag, and the count keeps running.
- R12: Read data appears on `bus_rdata` one clock after the read strobe. Unmapped offsets read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| irq | output | 1 | Compare interrupt, status AND enable |

## Verification
A compare match and a software clear of the status flag can land in the same clock edge. The bench provokes this by starting the counter from zero against a known target. It counts clocks from the start write and issues the clear so that it hits the exact edge at which the match would set the flag. It then judges at the port that `irq` stays high, and that a second, isolated clear drops it. A similar collision between the auto-add and a software write to the compare low word is checked by reading the target back: the written value must be there, not the stepped one.

// File: rtl/frc_pkg.sv
package frc_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned ADDR_W = 12;

    // register offsets (bytes)
    localparam int unsigned OFS_CNT_LO  = 'h100;
    localparam int unsigned OFS_CNT_HI  = 'h104;
    localparam int unsigned OFS_CMP_LO  = 'h200;
    localparam int unsigned OFS_CMP_HI  = 'h204;
    localparam int unsigned OFS_STEP    = 'h208;
    localparam int unsigned OFS_CTRL    = 'h240;
    localparam int unsigned OFS_STAT    = 'h244;
    localparam int unsigned OFS_IEN     = 'h248;

    // control bit positions
    localparam int unsigned BIT_RUN   = 8;
    localparam int unsigned BIT_AUTO  = 1;
    localparam int unsigned BIT_CMPEN = 0;

    typedef enum logic [1:0] {
        CMP_OFF   = 2'd0,
        CMP_ARMED = 2'd1,
        CMP_SPENT = 2'd2
    } cmp_state_e;

    typedef struct packed {
        logic run;
        logic auto_inc;
        logic cmp_en;
    } ctrl_t;

    typedef struct packed {
        logic cnt_lo;
        logic cnt_hi;
        logic cmp_lo;
        logic cmp_hi;
        logic step;
        logic ctrl;
        logic stat;
        logic ien;
    } wr_sel_t;
endpackage

// File: rtl/frc_regs.sv
module frc_regs
    import frc_pkg::*;
#(
    parameter int unsigned WORD_W = frc_pkg::WORD_W,
    parameter int unsigned ADDR_W = frc_pkg::ADDR_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                wd_run,
    input  logic                wd_auto,
    input  logic                wd_cmpen,
    input  logic                wd_ien,
    input  logic [2*WORD_W-1:0] count,
    input  logic [2*WORD_W-1:0] cmp_val,
    input  logic [WORD_W-1:0]   step_val,
    input  logic                status,
    output wr_sel_t             wr_sel,
    output ctrl_t               ctrl,
    output logic                int_en,
    output logic [WORD_W-1:0]   bus_rdata
);
    localparam int unsigned CNT_W = 2 * WORD_W;

    logic              wr_stb;
    logic              rd_stb;
    logic [WORD_W-1:0] rd_mux;

    assign wr_stb = bus_sel && bus_we;
    assign rd_stb = bus_sel && !bus_we;

    // write decode
    always_comb begin
        wr_sel = '0;
        if (wr_stb) begin
            case (bus_addr)
                ADDR_W'(OFS_CNT_LO): wr_sel.cnt_lo = 1'b1;
                ADDR_W'(OFS_CNT_HI): wr_sel.cnt_hi = 1'b1;
                ADDR_W'(OFS_CMP_LO): wr_sel.cmp_lo = 1'b1;
                ADDR_W'(OFS_CMP_HI): wr_sel.cmp_hi = 1'b1;
                ADDR_W'(OFS_STEP):   wr_sel.step   = 1'b1;
                ADDR_W'(OFS_CTRL):   wr_sel.ctrl   = 1'b1;
                ADDR_W'(OFS_STAT):   wr_sel.stat   = 1'b1;
                ADDR_W'(OFS_IEN):    wr_sel.ien    = 1'b1;
                default:             wr_sel        = '0;
            endcase
        end
    end

    // control and interrupt enable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl   <= '0;
            int_en <= 1'b0;
        end else begin
            if (wr_sel.ctrl) begin
                ctrl.run      <= wd_run;
                ctrl.auto_inc <= wd_auto;
                ctrl.cmp_en   <= wd_cmpen;
            end
            if (wr_sel.ien) begin
                int_en <= wd_ien;
            end
        end
    end

    // read mux
    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            ADDR_W'(OFS_CNT_LO): rd_mux = count[WORD_W-1:0];
            ADDR_W'(OFS_CNT_HI): rd_mux = count[CNT_W-1:WORD_W];
            ADDR_W'(OFS_CMP_LO): rd_mux = cmp_val[WORD_W-1:0];
            ADDR_W'(OFS_CMP_HI): rd_mux = cmp_val[CNT_W-1:WORD_W];
            ADDR_W'(OFS_STEP):   rd_mux = step_val;
            ADDR_W'(OFS_CTRL): begin
                rd_mux[BIT_RUN]   = ctrl.run;
                rd_mux[BIT_AUTO]  = ctrl.auto_inc;
                rd_mux[BIT_CMPEN] = ctrl.cmp_en;
            end
            ADDR_W'(OFS_STAT):   rd_mux[0] = status;
            ADDR_W'(OFS_IEN):    rd_mux[0] = int_en;
            default:             rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (rd_stb) begin
            bus_rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/frc_counter.sv
module frc_counter #(
    parameter int unsigned WORD_W = frc_pkg::WORD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                ld_lo,
    input  logic                ld_hi,
    input  logic [WORD_W-1:0]   wdata,
    output logic [2*WORD_W-1:0] count
);
    localparam int unsigned CNT_W = 2 * WORD_W;

    logic [CNT_W-1:0] count_nx;

    always_comb begin
        count_nx = count;
        if (ld_lo || ld_hi) begin
            if (ld_lo) count_nx[WORD_W-1:0]     = wdata;
            if (ld_hi) count_nx[CNT_W-1:WORD_W] = wdata;
        end else if (run) begin
            // full-width increment: carry reaches the upper word this clock
            count_nx = count + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count <= '0;
        else        count <= count_nx;
    end
endmodule

// File: rtl/frc_compare.sv
module frc_compare
    import frc_pkg::*;
#(
    parameter int unsigned WORD_W = frc_pkg::WORD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmp_en,
    input  logic                auto_inc,
    input  logic [2*WORD_W-1:0] count,
    input  logic                ld_lo,
    input  logic                ld_hi,
    input  logic                ld_step,
    input  logic [WORD_W-1:0]   wdata,
    output logic [2*WORD_W-1:0] cmp_val,
    output logic [WORD_W-1:0]   step_val,
    output logic                match
);
    localparam int unsigned CNT_W = 2 * WORD_W;

    cmp_state_e state_q, state_nx;
    logic       hit;
    logic       ld_any;
    logic       bump;

    assign hit    = (count == cmp_val);
    assign ld_any = ld_lo || ld_hi;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CMP_OFF;
        else        state_q <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            CMP_OFF: begin
                if (cmp_en) state_nx = CMP_ARMED;                // arm
            end
            CMP_ARMED: begin
                if (!cmp_en)              state_nx = CMP_OFF;    // disarm
                else if (hit && !auto_inc) state_nx = CMP_SPENT; // fire
                else                      state_nx = CMP_ARMED;  // repeat
            end
            CMP_SPENT: begin
                if (!cmp_en)     state_nx = CMP_OFF;             // disarm
                else if (ld_any) state_nx = CMP_ARMED;           // rearm
            end
            default: state_nx = CMP_OFF;
        endcase
    end

    // outputs
    always_comb begin
        match = 1'b0;
        bump  = 1'b0;
        unique case (state_q)
            CMP_ARMED: begin
                match = cmp_en && hit;
                bump  = cmp_en && hit && auto_inc && !ld_any;
            end
            CMP_OFF, CMP_SPENT: begin
                match = 1'b0;
                bump  = 1'b0;
            end
            default: begin
                match = 1'b0;
                bump  = 1'b0;
            end
        endcase
    end

    // compare target and step
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_val  <= '0;
            step_val <= '0;
        end else begin
            if (ld_lo) cmp_val[WORD_W-1:0]     <= wdata;
            if (ld_hi) cmp_val[CNT_W-1:WORD_W] <= wdata;
            if (bump)  cmp_val <= cmp_val + CNT_W'(step_val);
            if (ld_step) step_val <= wdata;
        end
    end
endmodule

// File: rtl/frc_irq.sv
module frc_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr_wr,
    input  logic clr_bit,
    input  logic int_en,
    output logic status,
    output logic irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                status <= 1'b0;
        else if (set)              status <= 1'b1;   // set beats clear
        else if (clr_wr && clr_bit) status <= 1'b0;
    end

    assign irq = status && int_en;
endmodule

// File: rtl/frc_cmp_timer.sv
module frc_cmp_timer
    import frc_pkg::*;
#(
    parameter int unsigned WORD_W = frc_pkg::WORD_W,
    parameter int unsigned ADDR_W = frc_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int unsigned CNT_W = 2 * WORD_W;

    wr_sel_t           wr_sel;
    ctrl_t             ctrl_q;
    logic              int_en_q;
    logic [CNT_W-1:0]  count_q;
    logic [CNT_W-1:0]  cmp_q;
    logic [WORD_W-1:0] step_q;
    logic              match;
    logic              status_q;
    logic              cnt_ld;
    logic              cmp_ld;
    logic              stat_clr;

    assign cnt_ld   = wr_sel.cnt_lo || wr_sel.cnt_hi;
    assign cmp_ld   = wr_sel.cmp_lo || wr_sel.cmp_hi;
    assign stat_clr = wr_sel.stat && bus_wdata[0];

    frc_regs #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .wd_run    (bus_wdata[BIT_RUN]),
        .wd_auto   (bus_wdata[BIT_AUTO]),
        .wd_cmpen  (bus_wdata[BIT_CMPEN]),
        .wd_ien    (bus_wdata[0]),
        .count     (count_q),
        .cmp_val   (cmp_q),
        .step_val  (step_q),
        .status    (status_q),
        .wr_sel    (wr_sel),
        .ctrl      (ctrl_q),
        .int_en    (int_en_q),
        .bus_rdata (bus_rdata)
    );

    frc_counter #(.WORD_W(WORD_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ctrl_q.run),
        .ld_lo (wr_sel.cnt_lo),
        .ld_hi (wr_sel.cnt_hi),
        .wdata (bus_wdata),
        .count (count_q)
    );

    frc_compare #(.WORD_W(WORD_W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmp_en   (ctrl_q.cmp_en),
        .auto_inc (ctrl_q.auto_inc),
        .count    (count_q),
        .ld_lo    (wr_sel.cmp_lo),
        .ld_hi    (wr_sel.cmp_hi),
        .ld_step  (wr_sel.step),
        .wdata    (bus_wdata),
        .cmp_val  (cmp_q),
        .step_val (step_q),
        .match    (match)
    );

    frc_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set     (match),
        .clr_wr  (wr_sel.stat),
        .clr_bit (bus_wdata[0]),
        .int_en  (int_en_q),
        .status  (status_q),
        .irq     (irq)
    );
endmodule

// File: rtl/frc_cmp_timer_chk.sv
module frc_cmp_timer_chk #(
    parameter int unsigned WORD_W = frc_pkg::WORD_W
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2*WORD_W-1:0] count,
    input logic                run,
    input logic                cnt_ld,
    input logic                match,
    input logic                auto_inc,
    input logic                cmp_ld,
    input logic [2*WORD_W-1:0] cmp_val,
    input logic [WORD_W-1:0]   step_val,
    input logic                status,
    input logic                stat_clr,
    input logic                cmp_en,
    input logic                int_en,
    input logic                irq
);
    localparam int unsigned CNT_W = 2 * WORD_W;

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run && !cnt_ld |=> count == $past(count) + CNT_W'(1));

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !cnt_ld |=> $stable(count));

    // R5
    match_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> status);

    // R7
    auto_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match && auto_inc && !cmp_ld |=> cmp_val == $past(cmp_val) + CNT_W'($past(step_val)));

    // R9
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr && !match |=> !status);

    // R11
    no_set_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_en && !status |=> !status);

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !int_en |-> !irq);
endmodule

bind frc_cmp_timer frc_cmp_timer_chk #(.WORD_W(WORD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .count    (count_q),
    .run      (ctrl_q.run),
    .cnt_ld   (cnt_ld),
    .match    (match),
    .auto_inc (ctrl_q.auto_inc),
    .cmp_ld   (cmp_ld),
    .cmp_val  (cmp_q),
    .step_val (step_q),
    .status   (status_q),
    .stat_clr (stat_clr),
    .cmp_en   (ctrl_q.cmp_en),
    .int_en   (int_en_q),
    .irq      (irq)
);

// File: tb/test_frc_cmp_timer.sv
module test_frc_cmp_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    frc_cmp_timer i_frc_cmp_timer (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // called at a negedge; access hits the next posedge; returns at the following negedge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic prep(input logic [31:0] cnt, input logic [31:0] cmp,
                        input logic [31:0] step, input logic ien);
        wr(12'h240, 32'h0);
        wr(12'h100, cnt);
        wr(12'h104, 32'h0);
        wr(12'h200, cmp);
        wr(12'h204, 32'h0);
        wr(12'h208, step);
        wr(12'h248, {31'b0, ien});
        wr(12'h244, 32'h1);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 irq", irq, 0);
        rd(12'h240, d); chk("R1 ctrl", d, 0);
        rd(12'h100, d); chk("R1 cnt lo", d, 0);
        rd(12'h204, d); chk("R1 cmp hi", d, 0);
        rd(12'h244, d); chk("R1 status", d, 0);
    endtask

    task automatic t_run_stop();
        logic [31:0] d;
        wr(12'h240, 32'h100);
        repeat (4) @(negedge clk);
        wr(12'h240, 32'h0);          // 5 increments
        rd(12'h100, d); chk("R2 run count", d, 5);
        repeat (3) @(negedge clk);
        rd(12'h100, d); chk("R2 hold count", d, 5);
    endtask

    task automatic t_preload_carry();
        logic [31:0] d;
        wr(12'h100, 32'hFFFF_FFFE);
        wr(12'h104, 32'h5);
        wr(12'h240, 32'h100);
        repeat (8) @(negedge clk);
        wr(12'h240, 32'h0);          // 9 increments across the carry
        rd(12'h104, d); chk("R3 carry hi", d, 6);
        rd(12'h100, d); chk("R3 carry lo", d, 7);
        wr(12'h104, 32'hA);
        rd(12'h100, d); chk("R3 half write keeps lo", d, 7);
        rd(12'h104, d); chk("R3 half write hi", d, 32'hA);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(12'h200, 32'h1234);
        wr(12'h204, 32'h55);
        wr(12'h208, 32'h77);
        rd(12'h200, d); chk("R4 cmp lo", d, 32'h1234);
        rd(12'h204, d); chk("R4 cmp hi", d, 32'h55);
        rd(12'h208, d); chk("R4 step", d, 32'h77);
        wr(12'h300, 32'hFFFF_FFFF);
        rd(12'h240, d); chk("R12 unmapped write", d, 0);
        rd(12'h000, d); chk("R12 unmapped read", d, 0);
        rd(12'h20C, d); chk("R12 unmapped read 20C", d, 0);
    endtask

    task automatic t_oneshot_stopped();
        logic [31:0] d;
        prep(50, 50, 0, 1'b1);
        wr(12'h240, 32'h1);
        repeat (2) @(negedge clk);
        chk("R5 match sets irq", irq, 1);
        rd(12'h244, d); chk("R5 status bit", d, 1);
        wr(12'h244, 32'h1);
        repeat (3) @(negedge clk);
        chk("R6 spent no refire", irq, 0);
        wr(12'h200, 32'd50);
        @(negedge clk);
        chk("R6 rearm on compare write", irq, 1);
    endtask

    task automatic t_irq_gate();
        logic [31:0] d;
        wr(12'h248, 32'h0);
        chk("R10 irq masked", irq, 0);
        rd(12'h244, d); chk("R10 status kept", d, 1);
        wr(12'h248, 32'h1);
        chk("R10 irq unmasked", irq, 1);
        wr(12'h244, 32'h0);
        chk("R9 write zero no effect", irq, 1);
        wr(12'h244, 32'h1);
        chk("R9 clear", irq, 0);
    endtask

    task automatic t_periodic();
        logic [31:0] d;
        prep(0, 20, 10, 1'b1);
        wr(12'h240, 32'h3);
        wr(12'h240, 32'h103);
        repeat (20) @(negedge clk);
        chk("R7 before first match", irq, 0);
        @(negedge clk);
        chk("R7 first match", irq, 1);
        wr(12'h244, 32'h1);
        chk("R7 cleared", irq, 0);
        repeat (8) @(negedge clk);
        chk("R7 before second match", irq, 0);
        @(negedge clk);
        chk("R7 second match", irq, 1);
        wr(12'h240, 32'h0);
        rd(12'h200, d); chk("R7 compare advanced", d, 40);
    endtask

    task automatic t_auto_collide();
        logic [31:0] d;
        prep(100, 7, 5, 1'b0);
        wr(12'h240, 32'h3);
        wr(12'h200, 32'd100);
        repeat (2) @(negedge clk);
        rd(12'h200, d); chk("R7 auto add", d, 105);
        wr(12'h200, 32'd100);
        wr(12'h200, 32'd300);        // lands on the auto-add edge
        repeat (2) @(negedge clk);
        rd(12'h200, d); chk("R8 write beats add", d, 300);
    endtask

    task automatic t_clear_collide();
        prep(0, 12, 0, 1'b1);
        wr(12'h240, 32'h1);
        wr(12'h240, 32'h101);
        repeat (12) @(negedge clk);
        wr(12'h244, 32'h1);          // same edge as the status set
        chk("R9 set wins over clear", irq, 1);
        wr(12'h244, 32'h1);
        chk("R9 later clear", irq, 0);
        repeat (5) @(negedge clk);
        chk("R6 one-shot stays quiet", irq, 0);
        wr(12'h240, 32'h0);
    endtask

    task automatic t_disable();
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] d;
        prep(0, 30, 0, 1'b1);
        wr(12'h240, 32'h100);
        repeat (40) @(negedge clk);
        rd(12'h244, d); chk("R11 no status when off", d, 0);
        chk("R11 irq low", irq, 0);
        rd(12'h100, a);
        repeat (3) @(negedge clk);
        rd(12'h100, b);
        chk("R11 counter keeps running", b - a, 4);
        wr(12'h240, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_run_stop();
        t_preload_carry();
        t_regs();
        t_oneshot_stopped();
        t_irq_gate();
        t_periodic();
        t_auto_collide();
        t_clear_collide();
        t_disable();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule